// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block computes a three-tap FIR filter over a sample stream that arrives three samples at a time. Each clock it takes one block of three consecutive samples and returns the three filtered results for those same sample instants. The filter therefore runs at three times the clock rate in samples per second. The critical path stays at one multiply and two additions, because each output lane is a separate copy of the tap sum.

The taps that reach back before the current block come from two registers. These registers keep the two newest samples of the last accepted block. Each of them is one clock deep, so each is worth three sample periods of delay. The coefficients are fixed at elaboration time through module parameters. Results are registered, and the valid flag is delayed by the same amount, so a consumer sees aligned data and valid.

Top module: `blkfir3_top`

## Requirements
- R1: Lane i of `in_blk` is bits [i*DW +: DW], and lane i of `out_blk` is bits [i*OW +: OW]. Lane 0 holds the oldest sample of the block and lane 2 the newest, on both sides.
- R2: Lane 0 of the output equals A·x0 + B·p2 + C·p1. Here x0..x2 are the current input lanes, p2 is lane 2 of the previous accepted block and p1 is lane 1 of the previous accepted block.
- R3: Lane 1 of the output equals A·x1 + B·x0 + C·p2.
- R4: Lane 2 of the output equals A·x2 + B·x1 + C·x0, and depends on the current block only.
- R5: The history registers take lanes 1 and 2 of every accepted block. After reset they are zero, so the first block after reset sees zero history.
- R6: Results for a block accepted at clock edge k appear on `out_blk` after edge k. `out_vld` is `in_vld` delayed by one clock.
- R7: While `in_vld` is low, `out_blk` and the history registers keep their values. The input data then has no effect on any later result.
- R8: While `rst` is high at a clock edge, `out_vld`, `out_blk` and the history are cleared, whatever `in_vld` and `in_blk` carry.
- R9: Samples and coefficients are signed two's complement. Outputs are full precision in OW = DW+CW+2 bits, so no combination of extreme inputs and coefficients wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | The input block is valid this cycle |
| in_blk | input | 3*DW | Three signed samples, lane 0 oldest |
| out_vld | output | 1 | The output block is valid |
| out_blk | output | 3*OW | Three signed results, lane 0 oldest |

## Verification
The bound checker checks on every clock edge that the valid flag is delayed by exactly one cycle and that the outputs and history hold while no block arrives. It also checks that reset clears everything, that the history captures the two newest lanes, and that the first and last lane results match their tap sums. Other behaviour needs the bench's scenarios. These cover zero history after reset and impulses moving from one block into the next. They also cover data ignored during gaps, and extreme negative values that would expose a lost sign bit or a truncated width.

// File: rtl/blkfir_pkg.sv
package blkfir_pkg;

    // Samples handled per clock (block size).
    localparam int LANES = 3;
    // Filter taps.
    localparam int TAPS  = 3;
    // Samples of history carried between blocks.
    localparam int HIST  = TAPS - 1;
    // Length of the sample window seen by all lanes together.
    localparam int WIN   = LANES + HIST;

    // Full-precision result width for a TAPS-term sum of products.
    function automatic int res_width(input int dw, input int cw);
        return dw + cw + 2;
    endfunction

endpackage

// File: rtl/blkfir3_hist.sv
module blkfir3_hist
    import blkfir_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [LANES*DW-1:0]  blk,
    output logic [HIST*DW-1:0]   hist
);

    // Entry j keeps input lane (LANES-HIST+j) of the last accepted block.
    // Entry 0 is the oldest.
    for (genvar j = 0; j < HIST; j++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                hist[j*DW +: DW] <= '0;
            end else if (en) begin
                hist[j*DW +: DW] <= blk[(LANES-HIST+j)*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/blkfir3_lane.sv
module blkfir3_lane #(
    parameter int                      DW     = 12,
    parameter int                      CW     = 10,
    parameter int                      OW     = DW + CW + 2,
    parameter logic signed [CW-1:0]    COEF_A = 3,
    parameter logic signed [CW-1:0]    COEF_B = -5,
    parameter logic signed [CW-1:0]    COEF_C = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic signed [DW-1:0]  s_new,
    input  logic signed [DW-1:0]  s_mid,
    input  logic signed [DW-1:0]  s_old,
    output logic signed [OW-1:0]  y_q
);

    localparam logic signed [OW-1:0] KA = OW'(COEF_A);
    localparam logic signed [OW-1:0] KB = OW'(COEF_B);
    localparam logic signed [OW-1:0] KC = OW'(COEF_C);

    logic signed [OW-1:0] e_new, e_mid, e_old;
    logic signed [OW-1:0] p_new, p_mid, p_old;
    logic signed [OW-1:0] sum;

    always_comb begin
        e_new = OW'(s_new);
        e_mid = OW'(s_mid);
        e_old = OW'(s_old);
        p_new = KA * e_new;
        p_mid = KB * e_mid;
        p_old = KC * e_old;
        sum   = p_new + p_mid + p_old;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= '0;
        end else if (en) begin
            y_q <= sum;
        end
    end

endmodule

// File: rtl/blkfir3_top.sv
module blkfir3_top
    import blkfir_pkg::*;
#(
    parameter int                      DW     = 12,
    parameter int                      CW     = 10,
    parameter logic signed [CW-1:0]    COEF_A = 3,
    parameter logic signed [CW-1:0]    COEF_B = -5,
    parameter logic signed [CW-1:0]    COEF_C = 7,
    parameter int                      OW     = res_width(DW, CW)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic [3*DW-1:0]      in_blk,
    output logic                 out_vld,
    output logic [3*OW-1:0]      out_blk
);

    logic [HIST*DW-1:0]   hist_q;
    logic signed [DW-1:0] win [WIN];

    blkfir3_hist #(.DW(DW)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .en   (in_vld),
        .blk  (in_blk),
        .hist (hist_q)
    );

    // Sample window: history first (oldest), then the current lanes.
    for (genvar j = 0; j < HIST; j++) begin : g_win_hist
        assign win[j] = hist_q[j*DW +: DW];
    end
    for (genvar i = 0; i < LANES; i++) begin : g_win_cur
        assign win[HIST+i] = in_blk[i*DW +: DW];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [OW-1:0] y_lane;
        blkfir3_lane #(
            .DW(DW), .CW(CW), .OW(OW),
            .COEF_A(COEF_A), .COEF_B(COEF_B), .COEF_C(COEF_C)
        ) u_lane (
            .clk   (clk),
            .rst   (rst),
            .en    (in_vld),
            .s_new (win[i+2]),
            .s_mid (win[i+1]),
            .s_old (win[i]),
            .y_q   (y_lane)
        );
        assign out_blk[i*OW +: OW] = y_lane;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
        end
    end

endmodule

// File: rtl/blkfir3_chk.sv
module blkfir3_chk #(
    parameter int                      DW     = 12,
    parameter int                      CW     = 10,
    parameter int                      OW     = DW + CW + 2,
    parameter logic signed [CW-1:0]    COEF_A = 3,
    parameter logic signed [CW-1:0]    COEF_B = -5,
    parameter logic signed [CW-1:0]    COEF_C = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [3*DW-1:0]   in_blk,
    input  logic              out_vld,
    input  logic [3*OW-1:0]   out_blk,
    input  logic [2*DW-1:0]   hist
);

    localparam logic signed [OW-1:0] KA = OW'(COEF_A);
    localparam logic signed [OW-1:0] KB = OW'(COEF_B);
    localparam logic signed [OW-1:0] KC = OW'(COEF_C);

    logic signed [OW-1:0] x0, x1, x2, p1, p2;
    logic signed [OW-1:0] want0, want2;

    always_comb begin
        x0 = OW'($signed(in_blk[0*DW +: DW]));
        x1 = OW'($signed(in_blk[1*DW +: DW]));
        x2 = OW'($signed(in_blk[2*DW +: DW]));
        p1 = OW'($signed(hist[0 +: DW]));
        p2 = OW'($signed(hist[DW +: DW]));
        want0 = KA * x0 + KB * p2 + KC * p1;
        want2 = KA * x2 + KB * x1 + KC * x0;
    end

    p_lane0_sum_r2: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> $signed(out_blk[0 +: OW]) == $past(want0));

    p_lane2_sum_r4: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> $signed(out_blk[2*OW +: OW]) == $past(want2));

    p_hist_load_r5: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> hist == $past(in_blk[3*DW-1:DW]));

    p_vld_rise_r6: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    p_vld_fall_r6: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_blk));

    p_hist_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(hist));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!out_vld && out_blk == '0 && hist == '0));

endmodule

bind blkfir3_top blkfir3_chk #(
    .DW(DW), .CW(CW), .OW(OW),
    .COEF_A(COEF_A), .COEF_B(COEF_B), .COEF_C(COEF_C)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_blk  (in_blk),
    .out_vld (out_vld),
    .out_blk (out_blk),
    .hist    (hist_q)
);

// File: tb/blkfir3_top_bench.sv
module blkfir3_top_bench;

    localparam int    CLK_PERIOD = 10;
    localparam int    DW = 12;
    localparam int    CW = 10;
    localparam int    OW = DW + CW + 2;
    localparam longint KA = 300;
    localparam longint KB = -512;
    localparam longint KC = 511;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_vld = 1'b0;
    logic [3*DW-1:0]   in_blk = '0;
    logic              out_vld;
    logic [3*OW-1:0]   out_blk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    longint h1 = 0;   // x(n-1) relative to the next block
    longint h2 = 0;   // x(n-2) relative to the next block

    blkfir3_top #(
        .DW(DW), .CW(CW),
        .COEF_A(CW'(KA)), .COEF_B(CW'(KB)), .COEF_C(CW'(KC))
    ) u_blkfir3_top (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_blk(in_blk),
        .out_vld(out_vld), .out_blk(out_blk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint lane_out(input int i);
        return longint'($signed(out_blk[i*OW +: OW]));
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: drives one block and checks it at the next falling edge.
    task automatic push(input string req, input int x0, input int x1, input int x2);
        longint s [5];
        longint e [3];
        s[0] = h2; s[1] = h1; s[2] = x0; s[3] = x1; s[4] = x2;
        for (int i = 0; i < 3; i++) e[i] = KA * s[i+2] + KB * s[i+1] + KC * s[i];
        in_vld = 1'b1;
        in_blk = {DW'(x2), DW'(x1), DW'(x0)};
        @(negedge clk);
        chk(req, "out_vld", longint'(out_vld), 1);
        chk(req, "lane0", lane_out(0), e[0]);
        chk(req, "lane1", lane_out(1), e[1]);
        chk(req, "lane2", lane_out(2), e[2]);
        h2 = x1;
        h1 = x2;
    endtask

    task automatic do_reset(input string req);
        rst = 1'b1;
        in_vld = 1'b1;
        in_blk = {DW'(1234), DW'(-77), DW'(555)};
        @(negedge clk);
        @(negedge clk);
        chk(req, "out_vld in reset", longint'(out_vld), 0);
        for (int i = 0; i < 3; i++) chk(req, "lane in reset", lane_out(i), 0);
        rst = 1'b0;
        in_vld = 1'b0;
        h1 = 0;
        h2 = 0;
    endtask

    task automatic t_reset_state();
        do_reset("R8");
    endtask

    task automatic t_first_block();
        // R5: zero history on the first block; R2/R3/R4 lane sums.
        push("R5", 10, -20, 30);
    endtask

    task automatic t_stream();
        // R2 R3 R4 R6: back-to-back ramp.
        for (int k = 0; k < 6; k++) push("R2", 3*k - 7, 3*k - 6, 3*k - 5);
        push("R3", 100, -100, 50);
        push("R4", -1, 2, -3);
    endtask

    task automatic t_gap();
        longint keep [3];
        push("R7", 40, 41, 42);
        for (int i = 0; i < 3; i++) keep[i] = lane_out(i);
        in_vld = 1'b0;
        for (int c = 0; c < 3; c++) begin
            in_blk = {DW'(-2048 + c), DW'(2047 - c), DW'(999)};
            @(negedge clk);
            chk("R6", "out_vld idle", longint'(out_vld), 0);
            for (int i = 0; i < 3; i++) chk("R7", "hold lane", lane_out(i), keep[i]);
        end
        // History must still be 41, 42 from the block before the gap.
        push("R7", 0, 0, 0);
    endtask

    task automatic t_impulse();
        // R1: impulse at lane 0 lands a, b, c in lanes 0, 1, 2.
        push("R1", 0, 0, 0);
        push("R1", 1, 0, 0);
        chk("R1", "imp0 lane0", lane_out(0), KA);
        chk("R1", "imp0 lane2", lane_out(2), KC);
        // Impulse at lane 2 spills b, c into the next block (R5).
        push("R1", 0, 0, 1);
        chk("R1", "imp2 lane2", lane_out(2), KA);
        push("R5", 0, 0, 0);
        chk("R5", "spill lane0", lane_out(0), KB);
        chk("R5", "spill lane1", lane_out(1), KC);
    endtask

    task automatic t_extremes();
        // R9: full-scale values, no wrap.
        push("R9", -2048, -2048, -2048);
        push("R9", -2048, -2048, -2048);
        push("R9", 2047, -2048, 2047);
        push("R9", -2048, 2047, -2048);
    endtask

    task automatic t_reset_mid();
        push("R8", 500, 600, 700);
        do_reset("R8");
        push("R8", 1, 2, 3);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_first_block();
        t_stream();
        t_gap();
        t_impulse();
        t_extremes();
        t_reset_mid();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule